// File: doc/BRIEF.md
# Cascaded Sampling Strobe Generator

This block derives every timing strobe a serial controller needs from one reference clock. A protocol stage runs either at the full reference rate or at half of it. A programmable divider derives a divided rate from the protocol rate. A four-way selector picks the sample source. Two further divide stages then bring that source down to the final sampling rate. A timing-measurement counter can run on either the protocol rate or the divided rate.

Every output is a clock-enable pulse that lasts one reference cycle. None of the outputs is a gated clock, so logic downstream stays in the single reference domain. All configuration inputs are static register fields. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control pins, and there is no back-pressure to honour.

Top module: `samp_strobe_chain`

## Requirements
- R1: With `half_rate`=0, `prot_stb` is high on every cycle while `run` is 1. With `half_rate`=1, it is high on every second cycle. The first pulse comes on the second cycle after `run` rises.
- R2: `div_stb` fires on every (`div_ratio`+1)-th `prot_stb` pulse. `div_ratio` is 10 bits wide, and 0 passes every pulse through.
- R3: `samp_sel` chooses the sample source `samp_stb` as follows. 0 selects `div_stb`, 1 selects `prot_stb`, 2 selects the serial bit clock rising edge and 3 selects the reference clock (high on every cycle while `run` is 1).
- R4: `bit_clk` passes through a two-flop synchroniser and then a rising-edge detector. A low-to-high transition gives exactly one pulse. That pulse is visible in the cycle after the second reference edge that samples the new level.
- R5: `pre_stb` fires on every (`pre_ratio`+1)-th `samp_stb` pulse. `pre_ratio` is 2 bits wide.
- R6: `den_stb` fires on every (`den_ratio`+1)-th `pre_stb` pulse. `den_ratio` is 5 bits wide.
- R7: `meas_count` is a 10-bit counter that wraps at its maximum value. While `meas_on`=1 it counts `prot_stb` pulses when `meas_src`=0 and `div_stb` pulses when `meas_src`=1. While `meas_on`=0 it holds its value.
- R8: Any change to a divide ratio restarts that stage's counter from zero. The stage gives no pulse in the cycle where the change is seen. A change of `samp_sel` restarts both sample stages in the same way.
- R9: While `run`=0, every strobe is low, every counter is held at zero and `meas_count` reads 0.
- R10: After reset, all counters are zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Controller enable; 0 holds the chain cleared |
| half_rate | input | 1 | Protocol source: 0 full rate, 1 half rate |
| div_ratio | input | 10 | Divided-rate ratio minus one |
| samp_sel | input | 2 | Sample source select |
| pre_ratio | input | 2 | Pre-divider ratio minus one |
| den_ratio | input | 5 | Denominator ratio minus one |
| meas_on | input | 1 | Measurement counter enable |
| meas_src | input | 1 | Measurement source: 0 protocol, 1 divided |
| bit_clk | input | 1 | Asynchronous serial bit clock |
| prot_stb | output | 1 | Protocol-rate enable |
| div_stb | output | 1 | Divided-rate enable |
| samp_stb | output | 1 | Selected sample source enable |
| pre_stb | output | 1 | Pre-divider output enable |
| den_stb | output | 1 | Final sampling enable |
| meas_count | output | 10 | Measurement counter value |

## Verification
The bench goes after four groups of corner cases.

- **Ratio changes in mid-count.** A design that failed to restart would emit one short or long period, and would fire in the cycle where the change is seen.
- **Sample selector switching.** A design that kept stale sample-stage counts would misplace the next `pre_stb` and `den_stb` pulses.
- **Serial bit clock.** A missing synchroniser stage shifts the pulse one cycle early. A level-sensitive detector gives repeated pulses while the clock stays high.
- **Measurement counter and disable.** The bench checks the wrap from 1023 to 0 and the hold while `meas_on` is low. It also drops `run` in mid-stream. A design that kept counting, or left counters in mid-period, would show wrong phases when `run` returns.

// File: rtl/samp_strobe_pkg.sv
package samp_strobe_pkg;
  typedef enum logic [1:0] {
    SRC_DIV  = 2'd0,
    SRC_PROT = 2'd1,
    SRC_BIT  = 2'd2,
    SRC_REF  = 2'd3
  } samp_src_e;
endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         stb
);
  logic [W-1:0] cnt;
  logic [W-1:0] ratio_q;
  logic         restart;
  logic         wrap;

  assign restart = !run || clr || (ratio != ratio_q);
  assign wrap    = (cnt == ratio);
  assign stb     = !restart && tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= '0;
    end else begin
      ratio_q <= ratio;
      if (restart)   cnt <= '0;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // R8: a restart leaves the counter at zero
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  // R9: no strobe while the chain is disabled
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !stb);
  // R2: a strobe only ever accompanies an input tick
  p_stb_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> tick);
endmodule

// File: rtl/bit_edge_sync.sv
module bit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = run && sync_q[STAGES-1] && !last_q;

  // R4: one pulse per edge, never two cycles in a row
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/meas_counter.sv
module meas_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         count_on,
  input  logic         tick,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value <= '0;
    else if (!run)              value <= '0;
    else if (count_on && tick)  value <= value + 1'b1;
  end

  // R7: counter holds while measurement is off
  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_on) |=> (value == $past(value)));
  // R9: disable clears the counter
  p_clear_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (value == '0));
endmodule

// File: rtl/samp_strobe_chain.sv
module samp_strobe_chain
  import samp_strobe_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int PRE_W  = 2,
  parameter int DEN_W  = 5,
  parameter int MEAS_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              half_rate,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [1:0]        samp_sel,
  input  logic [PRE_W-1:0]  pre_ratio,
  input  logic [DEN_W-1:0]  den_ratio,
  input  logic              meas_on,
  input  logic              meas_src,
  input  logic              bit_clk,
  output logic              prot_stb,
  output logic              div_stb,
  output logic              samp_stb,
  output logic              pre_stb,
  output logic              den_stb,
  output logic [MEAS_W-1:0] meas_count
);
  logic       half_ph;
  logic       bit_rise;
  logic [1:0] sel_q;
  logic       sel_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_ph <= 1'b0;
      sel_q   <= 2'd0;
    end else begin
      half_ph <= run ? !half_ph : 1'b0;
      sel_q   <= samp_sel;
    end
  end

  assign prot_stb = run && (half_rate ? half_ph : 1'b1);
  assign sel_chg  = (samp_sel != sel_q);

  strobe_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(1'b0),
    .tick(prot_stb), .ratio(div_ratio), .stb(div_stb));

  bit_edge_sync #(.STAGES(SYNC_STAGES)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(run), .async_in(bit_clk), .rise(bit_rise));

  always_comb begin
    unique case (samp_src_e'(samp_sel))
      SRC_DIV:  samp_stb = div_stb;
      SRC_PROT: samp_stb = prot_stb;
      SRC_BIT:  samp_stb = bit_rise;
      SRC_REF:  samp_stb = run;
      default:  samp_stb = 1'b0;
    endcase
  end

  strobe_div #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(sel_chg),
    .tick(samp_stb), .ratio(pre_ratio), .stb(pre_stb));

  strobe_div #(.W(DEN_W)) u_den (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(sel_chg),
    .tick(pre_stb), .ratio(den_ratio), .stb(den_stb));

  meas_counter #(.W(MEAS_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .run(run), .count_on(meas_on),
    .tick(meas_src ? div_stb : prot_stb), .value(meas_count));

  // R1: at half rate, protocol pulses never come back to back
  p_half_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && prot_stb) |=> (!prot_stb || !half_rate));
  // R2: divided strobe is a subset of protocol strobes
  p_div_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb |-> prot_stb);
  // R6: final strobe is a subset of pre-divider strobes
  p_den_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    den_stb |-> pre_stb);
  // R5: pre-divider strobe is a subset of sample strobes
  p_pre_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_stb |-> samp_stb);
  // R8: no sample-stage pulse in the cycle a source change is seen
  p_sel_change_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |-> !pre_stb);
endmodule

// File: tb/test_samp_strobe_chain.sv
module test_samp_strobe_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       half_rate = 1'b0;
  logic [9:0] div_ratio = '0;
  logic [1:0] samp_sel = '0;
  logic [1:0] pre_ratio = '0;
  logic [4:0] den_ratio = '0;
  logic       meas_on = 1'b0;
  logic       meas_src = 1'b0;
  logic       bit_clk = 1'b0;
  logic       prot_stb, div_stb, samp_stb, pre_stb, den_stb;
  logic [9:0] meas_count;

  always #2 clk = ~clk;

  samp_strobe_chain i_samp_strobe_chain (
    .clk(clk), .rst_n(rst_n), .run(run), .half_rate(half_rate),
    .div_ratio(div_ratio), .samp_sel(samp_sel), .pre_ratio(pre_ratio),
    .den_ratio(den_ratio), .meas_on(meas_on), .meas_src(meas_src),
    .bit_clk(bit_clk), .prot_stb(prot_stb), .div_stb(div_stb),
    .samp_stb(samp_stb), .pre_stb(pre_stb), .den_stb(den_stb),
    .meas_count(meas_count));

  // behavioural reference state
  int  m_half, m_s1, m_s2, m_last;
  int  m_dcnt, m_dq, m_pcnt, m_pq, m_ncnt, m_nq, m_selq, m_meas;
  int  n_vec = 0, n_bad = 0, cycles = 0;
  string phase = "R10";

  function automatic int exp_prot();
    return (run && (half_rate ? (m_half != 0) : 1'b1)) ? 1 : 0;
  endfunction
  function automatic int exp_div();
    if (!run || int'(div_ratio) != m_dq) return 0;
    return (exp_prot() == 1 && m_dcnt == int'(div_ratio)) ? 1 : 0;
  endfunction
  function automatic int exp_rise();
    return (run && m_s2 == 1 && m_last == 0) ? 1 : 0;
  endfunction
  function automatic int exp_samp();
    case (samp_sel)
      2'd0: return exp_div();
      2'd1: return exp_prot();
      2'd2: return exp_rise();
      default: return run ? 1 : 0;
    endcase
  endfunction
  function automatic int exp_pre();
    if (!run || int'(samp_sel) != m_selq || int'(pre_ratio) != m_pq) return 0;
    return (exp_samp() == 1 && m_pcnt == int'(pre_ratio)) ? 1 : 0;
  endfunction
  function automatic int exp_den();
    if (!run || int'(samp_sel) != m_selq || int'(den_ratio) != m_nq) return 0;
    return (exp_pre() == 1 && m_ncnt == int'(den_ratio)) ? 1 : 0;
  endfunction

  task automatic cmp(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp("R1 prot_stb", int'(prot_stb), exp_prot());
    cmp("R2 div_stb",  int'(div_stb),  exp_div());
    cmp("R3 samp_stb", int'(samp_stb), exp_samp());
    cmp("R5 pre_stb",  int'(pre_stb),  exp_pre());
    cmp("R6 den_stb",  int'(den_stb),  exp_den());
    cmp("R7 meas_count", int'(meas_count), m_meas);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_half = 0; m_s1 = 0; m_s2 = 0; m_last = 0;
      m_dcnt = 0; m_dq = 0; m_pcnt = 0; m_pq = 0;
      m_ncnt = 0; m_nq = 0; m_selq = 0; m_meas = 0;
    end else begin
      int p, d, s, pr, dn, rs_d, rs_p, rs_n;
      p = exp_prot(); d = exp_div(); s = exp_samp(); pr = exp_pre(); dn = exp_den();
      rs_d = (!run || int'(div_ratio) != m_dq) ? 1 : 0;
      rs_p = (!run || int'(samp_sel) != m_selq || int'(pre_ratio) != m_pq) ? 1 : 0;
      rs_n = (!run || int'(samp_sel) != m_selq || int'(den_ratio) != m_nq) ? 1 : 0;
      if (rs_d != 0) m_dcnt = 0; else if (p != 0) m_dcnt = (d != 0) ? 0 : m_dcnt + 1;
      if (rs_p != 0) m_pcnt = 0; else if (s != 0) m_pcnt = (pr != 0) ? 0 : m_pcnt + 1;
      if (rs_n != 0) m_ncnt = 0; else if (pr != 0) m_ncnt = (dn != 0) ? 0 : m_ncnt + 1;
      if (!run) m_meas = 0;
      else if (meas_on && ((meas_src ? d : p) != 0)) m_meas = (m_meas + 1) % 1024;
      m_last = m_s2; m_s2 = m_s1; m_s1 = int'(bit_clk);
      m_half = run ? 1 - m_half : 0;
      m_dq = int'(div_ratio); m_pq = int'(pre_ratio); m_nq = int'(den_ratio);
      m_selq = int'(samp_sel);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_toggle(int periods, int half_len);
    for (int i = 0; i < periods; i++) begin
      bit_clk = 1'b1; step(half_len);
      bit_clk = 1'b0; step(half_len);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    // R10: reset state, R9: disabled state
    phase = "R10"; step(4); rst_n = 1'b1; step(6);
    phase = "R2/R5/R6";
    div_ratio = 10'd3; pre_ratio = 2'd1; den_ratio = 5'd2; meas_on = 1'b1;
    run = 1'b1; step(200);
    phase = "R1"; half_rate = 1'b1; step(200);
    phase = "R3"; samp_sel = 2'd1; step(60); samp_sel = 2'd3; step(60);
    phase = "R4"; samp_sel = 2'd2; pre_ratio = 2'd0; den_ratio = 5'd1;
    bit_toggle(20, 5); bit_toggle(10, 1);
    phase = "R8"; samp_sel = 2'd0; step(37);
    div_ratio = 10'd0; step(23); pre_ratio = 2'd3; step(41);
    den_ratio = 5'd0; step(29); den_ratio = 5'd31; step(400);
    samp_sel = 2'd3; step(11); samp_sel = 2'd1; step(50);
    phase = "R7"; half_rate = 1'b0; meas_src = 1'b0; step(1100);
    meas_on = 1'b0; step(50); meas_on = 1'b1; meas_src = 1'b1; div_ratio = 10'd4; step(300);
    phase = "R2 max"; div_ratio = 10'd1023; samp_sel = 2'd0; pre_ratio = 2'd0; den_ratio = 5'd0;
    step(2200);
    phase = "R9"; div_ratio = 10'd2; step(17); run = 1'b0; step(30);
    run = 1'b1; half_rate = 1'b1; step(150);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog expired (phase %s)", phase);
    finish_run();
  end
endmodule